// File: doc/BRIEF.md
# Serial-Load Latched Output Driver

This block takes a bit stream on a serial data pin and a slow shift clock, both coming from outside the chip's timing domain. It collects the bits in a shift chain, moves them into a holding latch under a strobe, and presents them on a bank of parallel driver outputs. The outputs are modelled as inverting open-collector signals: a low level means the driver is on, and a high level means it is off or floating. A serial output shows the last stage of the chain, so several blocks can be chained into a longer register.

The shift clock, the strobe and the serial data are each passed through a two-flop synchroniser into the system clock. A shift happens one system cycle after the synchronised shift clock is seen rising. While the synchronised strobe is high, the latch follows the chain directly. While it is low, the latch keeps its value. An active-high disable input turns every driver off at once. It does not touch the chain or the latch, so clearing it brings back the pattern that was held. A warning output pulses when a shift takes place while the latch is transparent and the drivers are enabled, because in that state the outputs ripple as the bits move through.

Top module: `svl_driver`

## Requirements
- R1: A synchronous reset sets every chain stage and every latch bit to 0. After reset all drv_n bits are 1 and ser_out is 0.
- R2: A low-to-high transition on shift_clk causes one shift within four system clocks. Stage 1 (drv_n bit 0 side) takes ser_in, and each stage k takes the old value of stage k-1. ser_in must be held steady from three system clocks before the transition until four system clocks after it.
- R3: The chain changes only on a shift_clk rise. A shift_clk that is held high or held low causes no further shifts.
- R4: ser_out equals the last stage of the chain (stage W, index W-1).
- R5: While strobe is high, every latch bit follows its chain stage, including across shifts that happen while strobe stays high.
- R6: While strobe is low, the latch keeps its value whatever happens in the chain.
- R7: While out_off is 1, every drv_n bit is 1. Neither the chain nor the latch is altered by out_off, and both keep working while it is 1.
- R8: While out_off is 0, drv_n[i] is 0 when latch bit i is 1, and 1 when latch bit i is 0.
- R9: ripple_warn is 1 for the one system cycle in which a shift occurs while the synchronised strobe is high and out_off is 0. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 1 |
| shift_clk | input | 1 | External shift clock; a shift happens on its rise |
| strobe | input | 1 | Latch transparency control, high = follow |
| out_off | input | 1 | Driver disable, high = all drivers off |
| drv_n | output | W | Driver outputs, low = on |
| ser_out | output | 1 | Last chain stage, for cascading |
| ripple_warn | output | 1 | Pulse when the chain shifts with the latch open and drivers enabled |

## Verification
The assertions assume that shift_clk and strobe change slowly compared with the system clock. Each level must last at least three system cycles, so the synchronisers deliver clean single edges, and ser_in must stay steady around each shift_clk rise. The bench drives every input on the falling system clock edge and holds each level for at least three cycles. It also checks its results only after the four-cycle synchronisation and shift latency has passed. The stimulus loads every 8-bit value with the strobe low and then opens the latch. It also runs cases that shift while the strobe is high, both with the drivers enabled and disabled.

// File: rtl/svl_pkg.sv
package svl_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic data;
    logic clk_lvl;
    logic stb_lvl;
  } sync_bus_t;
endpackage

// File: rtl/svl_sync.sv
module svl_sync #(
  parameter int unsigned DEPTH = svl_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level
);
  logic [DEPTH-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[g] <= rst ? 1'b0 : async_in;
      end else begin : g_rest
        always_ff @(posedge clk) chain[g] <= rst ? 1'b0 : chain[g-1];
      end
    end
  endgenerate

  assign level = chain[DEPTH-1];
endmodule

// File: rtl/svl_shift.sv
module svl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         din,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic bit_in);
    step = {cur[W-2:0], bit_in};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (advance) q <= step(q, din);
  end
endmodule

// File: rtl/svl_latch.sv
module svl_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  assign q = open_i ? d : held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= q;
  end
endmodule

// File: rtl/svl_driver.sv
module svl_driver #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_in,
  input  logic         shift_clk,
  input  logic         strobe,
  input  logic         out_off,
  output logic [W-1:0] drv_n,
  output logic         ser_out,
  output logic         ripple_warn
);
  import svl_pkg::*;

  sync_bus_t    sb;
  logic         clk_prev;
  logic         shift_rise;
  logic         stb_s;
  logic [W-1:0] sr_q;
  logic [W-1:0] lat_q;

  function automatic logic [W-1:0] pin_levels(input logic [W-1:0] lat, input logic off);
    pin_levels = off ? {W{1'b1}} : ~lat;
  endfunction

  svl_sync #(.DEPTH(SYNC_DEPTH)) u_sync_d (.clk(clk), .rst(rst), .async_in(ser_in),    .level(sb.data));
  svl_sync #(.DEPTH(SYNC_DEPTH)) u_sync_c (.clk(clk), .rst(rst), .async_in(shift_clk), .level(sb.clk_lvl));
  svl_sync #(.DEPTH(SYNC_DEPTH)) u_sync_s (.clk(clk), .rst(rst), .async_in(strobe),    .level(sb.stb_lvl));

  always_ff @(posedge clk) clk_prev <= rst ? 1'b0 : sb.clk_lvl;

  assign shift_rise = sb.clk_lvl & ~clk_prev;
  assign stb_s      = sb.stb_lvl;

  svl_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .advance(shift_rise), .din(sb.data), .q(sr_q)
  );

  svl_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .open_i(stb_s), .d(sr_q), .q(lat_q)
  );

  assign drv_n       = pin_levels(lat_q, out_off);
  assign ser_out     = sr_q[W-1];
  assign ripple_warn = shift_rise & stb_s & ~out_off;
endmodule

// File: rtl/svl_driver_chk.sv
module svl_driver_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_rise,
  input logic         stb_s,
  input logic         out_off,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] drv_n
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (sr_q == '0));

  a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
    shift_rise |=> (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !shift_rise |=> $stable(sr_q));

  a_r5_follow: assert property (@(posedge clk) disable iff (rst)
    stb_s |-> (lat_q == sr_q));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !stb_s |=> (stb_s || $stable(lat_q)));

  a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
    out_off |-> (&drv_n));

  a_r8_drive: assert property (@(posedge clk) disable iff (rst)
    !out_off |-> (drv_n == ~lat_q));
endmodule

bind svl_driver svl_driver_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .shift_rise(shift_rise), .stb_s(stb_s),
  .out_off(out_off), .sr_q(sr_q), .lat_q(lat_q), .drv_n(drv_n)
);

// File: tb/svl_driver_bench.sv
module svl_driver_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, ser_in, shift_clk, strobe, out_off;
  logic [W-1:0] drv_n;
  logic ser_out, ripple_warn;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic warn_seen = 1'b0;
  logic [W-1:0] m_sr, m_lat;

  always #2.5 clk = ~clk;

  svl_driver #(.W(W)) u_svl_driver (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
    .strobe(strobe), .out_off(out_off), .drv_n(drv_n),
    .ser_out(ser_out), .ripple_warn(ripple_warn)
  );

  always @(posedge clk) if (ripple_warn) warn_seen <= 1'b1;

  function automatic logic [W-1:0] expect_pins(input logic [W-1:0] lat, input logic off);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = off | ~lat[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    wait_n(3);
    shift_clk = 1'b1;
    wait_n(4);
    shift_clk = 1'b0;
    wait_n(4);
    m_sr = {m_sr[W-2:0], b};
    if (strobe) m_lat = m_sr;
  endtask

  task automatic set_strobe(input logic v);
    strobe = v;
    wait_n(4);
    if (v) m_lat = m_sr;
  endtask

  initial begin
    rst = 1'b1; ser_in = 0; shift_clk = 0; strobe = 0; out_off = 0;
    m_sr = '0; m_lat = '0;
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R1: reset state
    check("R1 drv_n", drv_n, '1);
    check("R1 ser_out", {7'b0, ser_out}, 8'h00);

    // R2 R4 R6 R8: exhaustive load with strobe low, then latch
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] pre;
      pre = drv_n;
      for (int k = W - 1; k >= 0; k--) begin
        shift_bit(v[k]);
        check("R4 ser_out", {7'b0, ser_out}, {7'b0, m_sr[W-1]});
      end
      check("R6 hold while strobe low", drv_n, pre);
      set_strobe(1'b1);
      set_strobe(1'b0);
      check("R8 pins after latch", drv_n, expect_pins(v[7:0], 1'b0));
    end

    // R3: shift clock held high for a long time gives exactly one shift
    set_strobe(1'b1);
    out_off = 1'b1;
    ser_in = 1'b1;
    wait_n(3);
    shift_clk = 1'b1;
    wait_n(20);
    m_sr = {m_sr[W-2:0], 1'b1}; m_lat = m_sr;
    out_off = 1'b0;
    wait_n(1);
    check("R3 single shift on held clock", drv_n, expect_pins(m_lat, 1'b0));
    out_off = 1'b1;
    shift_clk = 1'b0;
    wait_n(20);
    out_off = 1'b0;
    wait_n(1);
    check("R3 no shift on falling clock", drv_n, expect_pins(m_lat, 1'b0));

    // R7: disable forces off, shifting continues with strobe open, no warning
    out_off = 1'b1;
    wait_n(1);
    check("R7 all off", drv_n, '1);
    warn_seen = 1'b0;
    shift_bit(1'b0);
    shift_bit(1'b1);
    check("R7 still off", drv_n, '1);
    check("R9 no warn while off", {7'b0, warn_seen}, 8'h00);
    out_off = 1'b0;
    wait_n(1);
    check("R7 state kept through disable", drv_n, expect_pins(m_lat, 1'b0));

    // R5: latch follows chain while strobe stays high
    warn_seen = 1'b0;
    shift_bit(1'b0);
    check("R5 follow during shift", drv_n, expect_pins(m_lat, 1'b0));
    check("R9 warn on ripple", {7'b0, warn_seen}, 8'h01);
    shift_bit(1'b1);
    check("R5 follow second shift", drv_n, expect_pins(m_lat, 1'b0));

    // R6 R7: latch kept across disable with strobe low while chain moves
    set_strobe(1'b0);
    out_off = 1'b1;
    warn_seen = 1'b0;
    for (int k = 0; k < 3; k++) shift_bit(k[0]);
    out_off = 1'b0;
    wait_n(1);
    check("R6 latch unchanged", drv_n, expect_pins(m_lat, 1'b0));
    check("R9 no warn with strobe low", {7'b0, warn_seen}, 8'h00);
    check("R4 ser_out after mix", {7'b0, ser_out}, {7'b0, m_sr[W-1]});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule